// File: doc/BRIEF.md
# Radix-16 Shift-and-Add Number-Theoretic Transform Butterfly

This block computes a full 16-point number-theoretic transform on every cycle. The transform works over the prime field p = 2^64 - 2^32 + 1. It accepts one set of sixteen 64-bit residues together with a direction flag. After a fixed five-cycle delay it presents the sixteen transformed residues. The block is the arithmetic core of a memory-based transform engine. The surrounding engine supplies the data sets and applies the twiddle factors between passes.

The prime is chosen so that 2^12 is a primitive 16th root of unity. In this field 2^96 is congruent to -1, so each root-of-unity product reduces to two operations: a constant left shift, and a choice between the positive and the negative accumulator. Each output is formed as two wide sums, one for positive terms and one for negative terms. The sums are held in 192-bit words. Each sum is then folded back to a canonical residue using 2^64 ≡ 2^32 - 1 and 2^96 ≡ -1, and the difference of the two residues is taken mod p.

Top module: `ntt16_butterfly`

## Requirements
- R1: While reset is held and for the first cycles after it, valid_o is 0 and data_o is all zeros.
- R2: In forward mode (inv_i = 0), lane k of data_o equals the sum over n of data_i[n]·2^(12·n·k) mod p. Lane n of a data port occupies bits [64n+63:64n].
- R3: In inverse mode (inv_i = 1), lane k equals the sum over n of data_i[n]·2^(-12·n·k) mod p. The 1/16 scale factor is not applied.
- R4: Every lane of data_o is below p whenever valid_o is 1.
- R5: valid_o is valid_i delayed by exactly five clock cycles, and the result for a set appears in that same cycle.
- R6: One new set is accepted on every cycle. Back-to-back sets produce back-to-back correct results in order.
- R7: The direction flag is captured with its data set, so consecutive sets may use different directions.
- R8: Inputs at the upper field boundary (p - 1 in every lane) produce exact results.
- R9: data_o holds its value on every cycle in which valid_o is 0.
- R10: Input words at or above p (up to 2^64 - 1) are treated as their value mod p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input set present this cycle |
| inv_i | input | 1 | 1 selects inverse roots for this set |
| data_i | input | 16x64 | Sixteen input residues, lane n at bits [64n+63:64n] |
| valid_o | output | 1 | Output set present this cycle |
| data_o | output | 16x64 | Sixteen transformed residues |

## Verification
The assertions check several properties on every cycle:
- valid_o follows valid_i at the exact five-cycle delay.
- Every output lane is canonical (below p).
- The outputs hold their value while no result is flagged.
- An all-zero set always yields an all-zero result.

The transform values themselves can only be shown by the bench's scenarios. The bench compares each lane against a direct 16-point sum built from repeated modular doubling. The scenarios cover single impulses, random sets in both directions, the p - 1 and 2^64 - 1 boundaries, and a back-to-back stream that mixes directions.

// File: rtl/ntt16_pkg.sv
`timescale 1ns/1ps
package ntt16_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned WIDE_W  = 3 * DATA_W;
  localparam int unsigned PTS     = 16;
  localparam int unsigned HALF_PT = PTS / 2;
  localparam int unsigned ROOT_SH = 12;
  localparam int unsigned NSTG    = 5;

  typedef logic [DATA_W-1:0] res_t;
  typedef logic [WIDE_W-1:0] wide_t;
  typedef logic [DATA_W+1:0] part_t;

  localparam res_t PRIME = {{HALF_W{1'b1}}, {(HALF_W-1){1'b0}}, 1'b1};

  // v < 2^65 < 3p, so two conditional subtractions suffice
  function automatic res_t red_part(input part_t v);
    part_t p1;
    part_t p2;
    p1 = {2'b00, PRIME};
    p2 = p1 << 1;
    if (v >= p2)      red_part = res_t'(v - p2);
    else if (v >= p1) red_part = res_t'(v - p1);
    else              red_part = res_t'(v);
  endfunction

  // a, b canonical; wraps in DATA_W bits to the right residue
  function automatic res_t mod_sub(input res_t a, input res_t b);
    if (a >= b) mod_sub = a - b;
    else        mod_sub = a - b + PRIME;
  endfunction
endpackage

// File: rtl/ntt16_accum.sv
`timescale 1ns/1ps
module ntt16_accum import ntt16_pkg::*; #(
  parameter int unsigned K = 0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        inv_i,
  input  logic [PTS-1:0][DATA_W-1:0]  x_i,
  output wide_t                       pos_o,
  output wide_t                       neg_o
);
  wide_t    term [PTS];
  logic [PTS-1:0] is_neg;

  for (genvar n = 0; n < PTS; n++) begin : g_term
    localparam int unsigned EF = (n * K) % PTS;
    localparam int unsigned EI = (PTS - EF) % PTS;
    localparam int unsigned SF = ROOT_SH * (EF % HALF_PT);
    localparam int unsigned SI = ROOT_SH * (EI % HALF_PT);
    localparam logic        NF = (EF >= HALF_PT);
    localparam logic        NI = (EI >= HALF_PT);
    wide_t tf;
    wide_t ti;
    assign tf = wide_t'(x_i[n]) << SF;
    assign ti = wide_t'(x_i[n]) << SI;
    // root 2^(12e), e >= 8 contributes with 2^96 = -1
    assign term[n]   = inv_i ? ti : tf;
    assign is_neg[n] = inv_i ? NI : NF;
  end

  wide_t psum, nsum;
  always_comb begin
    psum = '0;
    nsum = '0;
    for (int n = 0; n < PTS; n++) begin
      if (is_neg[n]) nsum = nsum + term[n];
      else           psum = psum + term[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o <= '0;
      neg_o <= '0;
    end else if (en_i) begin
      pos_o <= psum;
      neg_o <= nsum;
    end
  end
endmodule

// File: rtl/ntt16_fold.sv
`timescale 1ns/1ps
module ntt16_fold import ntt16_pkg::*; (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_a_i,
  input  logic   en_b_i,
  input  wide_t  wide_i,
  output res_t   res_o
);
  localparam int unsigned C1_LO = DATA_W;
  localparam int unsigned D0_LO = DATA_W + HALF_W;
  localparam int unsigned D1_LO = 2 * DATA_W + HALF_W;

  logic [DATA_W-1:0] c0, d0;
  logic [HALF_W-1:0] c1, d1;
  part_t             pa_d, na_d, pa_q, na_q;

  assign c0 = wide_i[DATA_W-1:0];
  assign c1 = wide_i[D0_LO-1:C1_LO];
  assign d0 = wide_i[D1_LO-1:D0_LO];
  assign d1 = wide_i[WIDE_W-1:D1_LO];

  // bits below 2^96 fold with 2^64 = 2^32-1; bits above carry a minus sign
  assign pa_d = part_t'(c0) + (part_t'(c1) << HALF_W) - part_t'(c1);
  assign na_d = part_t'(d0) + (part_t'(d1) << HALF_W) - part_t'(d1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= '0;
      na_q <= '0;
    end else if (en_a_i) begin
      pa_q <= pa_d;
      na_q <= na_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_o <= '0;
    else if (en_b_i)  res_o <= mod_sub(red_part(pa_q), red_part(na_q));
  end
endmodule

// File: rtl/ntt16_out.sv
`timescale 1ns/1ps
module ntt16_out import ntt16_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  res_t a_i,
  input  res_t b_i,
  output res_t res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_o <= '0;
    else if (en_i)  res_o <= mod_sub(a_i, b_i);
  end
endmodule

// File: rtl/ntt16_butterfly.sv
`timescale 1ns/1ps
module ntt16_butterfly import ntt16_pkg::*; (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        inv_i,
  input  logic [PTS-1:0][DATA_W-1:0]  data_i,
  output logic                        valid_o,
  output logic [PTS-1:0][DATA_W-1:0]  data_o
);
  logic [NSTG-1:0]             vld_q;
  logic [PTS-1:0][DATA_W-1:0]  x_q;
  logic                        inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[NSTG-2:0], valid_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      inv_q <= 1'b0;
    end else if (valid_i) begin
      x_q   <= data_i;
      inv_q <= inv_i;
    end
  end

  for (genvar k = 0; k < PTS; k++) begin : g_lane
    wide_t pos_w, neg_w;
    res_t  pos_r, neg_r;

    ntt16_accum #(.K(k)) u_acc (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_i(vld_q[0]),
      .inv_i (inv_q), .x_i(x_q), .pos_o(pos_w), .neg_o(neg_w)
    );
    ntt16_fold u_fold_p (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_a_i(vld_q[1]), .en_b_i(vld_q[2]),
      .wide_i(pos_w), .res_o(pos_r)
    );
    ntt16_fold u_fold_n (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_a_i(vld_q[1]), .en_b_i(vld_q[2]),
      .wide_i(neg_w), .res_o(neg_r)
    );
    ntt16_out u_out (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_i(vld_q[3]),
      .a_i   (pos_r), .b_i(neg_r), .res_o(data_o[k])
    );
  end

  assign valid_o = vld_q[NSTG-1];
endmodule

// File: rtl/ntt16_butterfly_chk.sv
`timescale 1ns/1ps
module ntt16_butterfly_chk import ntt16_pkg::*; (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        valid_i,
  input logic [PTS-1:0][DATA_W-1:0]  data_i,
  input logic                        valid_o,
  input logic [PTS-1:0][DATA_W-1:0]  data_o
);
  logic [2:0] cyc_q;
  logic       lanes_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end

  always_comb begin
    lanes_ok = 1'b1;
    for (int k = 0; k < PTS; k++)
      if (data_o[k] >= PRIME) lanes_ok = 1'b0;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < 3'd5) |-> !valid_o);

  a_r5_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 3'd7) |-> (valid_o == $past(valid_i, 5)));

  a_r4_canonical: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> lanes_ok);

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_q == 3'd7) && !valid_o) |-> $stable(data_o));

  a_r2_zero_in_zero_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_q == 3'd7) && $past(valid_i && (data_i == '0), 5)) |-> (data_o == '0));
endmodule

bind ntt16_butterfly ntt16_butterfly_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .data_i (data_i),
  .valid_o(valid_o),
  .data_o (data_o)
);

// File: tb/sim_ntt16_butterfly.sv
`timescale 1ns/1ps
module sim_ntt16_butterfly;
  import ntt16_pkg::*;

  typedef logic [PTS-1:0][DATA_W-1:0] vec_t;
  localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;

  logic clk_i = 1'b0;
  logic rst_ni, valid_i, inv_i, valid_o;
  vec_t data_i, data_o;
  int   errs = 0, checks = 0;
  bit   done = 0;

  always #10 clk_i = ~clk_i;

  ntt16_butterfly u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .inv_i(inv_i),
    .data_i(data_i), .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic [63:0] dbl_mod(input logic [63:0] v);
    logic [64:0] t;
    t = {v, 1'b0};
    if (t >= {1'b0, P}) t = t - {1'b0, P};
    return t[63:0];
  endfunction

  function automatic logic [63:0] add_mod(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (t >= {1'b0, P}) t = t - {1'b0, P};
    return t[63:0];
  endfunction

  function automatic logic [63:0] ref_lane(input vec_t x, input int k, input bit inv);
    logic [63:0] acc, v;
    int e;
    acc = '0;
    for (int n = 0; n < 16; n++) begin
      e = (n * k) % 16;
      if (inv) e = (16 - e) % 16;
      v = x[n];
      if (v >= P) v = v - P;
      for (int s = 0; s < 12 * e; s++) v = dbl_mod(v);
      acc = add_mod(acc, v);
    end
    return acc;
  endfunction

  function automatic vec_t rand_vec();
    vec_t r;
    for (int n = 0; n < 16; n++) r[n] = {$urandom, $urandom};
    return r;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: valid_o=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_set(input string req, input vec_t x, input bit inv);
    logic [63:0] e;
    bit bad;
    bad = 0;
    checks++;
    for (int k = 0; k < 16; k++) begin
      e = ref_lane(x, k, inv);
      if (!bad && data_o[k] !== e) begin
        bad = 1;
        errs++;
        $display("FAIL %s: lane %0d actual %h expected %h", req, k, data_o[k], e);
      end
    end
  endtask

  // drive at N0, result sampled at N5 with valid_o low at N4
  task automatic run_one(input string req, input vec_t x, input bit inv);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = x; inv_i = inv;
    @(negedge clk_i);
    valid_i = 1'b0; data_i = rand_vec(); inv_i = ~inv;
    repeat (3) @(negedge clk_i);
    chk_bit({req, "/R5 early"}, valid_o, 1'b0);
    @(negedge clk_i);
    chk_bit({req, "/R5 on time"}, valid_o, 1'b1);
    chk_set(req, x, inv);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; valid_i = 1'b1; inv_i = 1'b0; data_i = rand_vec();
    repeat (3) @(negedge clk_i);
    chk_bit("R1 in reset", valid_o, 1'b0);
    checks++;
    if (data_o !== '0) begin
      errs++;
      $display("FAIL R1: data_o=%h expected 0", data_o);
    end
    valid_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_bit("R1 after reset", valid_o, 1'b0);
  endtask

  task automatic t_impulse();
    vec_t x;
    x = '0; x[0] = 64'd1;
    run_one("R2 impulse lane0", x, 1'b0);
    x = '0; x[1] = 64'd1;
    run_one("R2 impulse lane1", x, 1'b0);
    x = '0; x[5] = 64'd7;
    run_one("R3 impulse lane5 inverse", x, 1'b1);
    run_one("R2 zero set", '0, 1'b0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 4; i++) run_one("R2 random forward", rand_vec(), 1'b0);
    for (int i = 0; i < 4; i++) run_one("R3 random inverse", rand_vec(), 1'b1);
  endtask

  task automatic t_boundary();
    vec_t x;
    for (int n = 0; n < 16; n++) x[n] = P - 64'd1;
    run_one("R8 all p-1 forward", x, 1'b0);
    run_one("R8 all p-1 inverse", x, 1'b1);
    for (int n = 0; n < 16; n++) x[n] = '1;
    run_one("R10 all 2^64-1", x, 1'b0);
    for (int n = 0; n < 16; n++) x[n] = (n % 2 == 0) ? P : P + 64'd3;
    run_one("R10 p and p+3", x, 1'b1);
  endtask

  task automatic t_stream();
    vec_t a, b, c;
    a = rand_vec(); b = rand_vec(); c = rand_vec();
    @(negedge clk_i); valid_i = 1'b1; data_i = a; inv_i = 1'b0;
    @(negedge clk_i); data_i = b; inv_i = 1'b1;
    @(negedge clk_i); data_i = c; inv_i = 1'b0;
    @(negedge clk_i); valid_i = 1'b0; data_i = rand_vec();
    @(negedge clk_i);
    chk_bit("R5 stream early", valid_o, 1'b0);
    @(negedge clk_i);
    chk_bit("R6 stream first", valid_o, 1'b1);
    chk_set("R6 stream set a", a, 1'b0);
    @(negedge clk_i);
    chk_bit("R6 stream second", valid_o, 1'b1);
    chk_set("R7 stream set b inverse", b, 1'b1);
    @(negedge clk_i);
    chk_bit("R6 stream third", valid_o, 1'b1);
    chk_set("R7 stream set c forward", c, 1'b0);
    @(negedge clk_i);
    chk_bit("R5 stream end", valid_o, 1'b0);
  endtask

  task automatic t_hold();
    vec_t x;
    x = rand_vec();
    run_one("R9 hold setup", x, 1'b0);
    for (int i = 0; i < 4; i++) begin
      data_i = rand_vec(); inv_i = ~inv_i;
      @(negedge clk_i);
    end
    chk_bit("R9 idle", valid_o, 1'b0);
    chk_set("R9 held output", x, 1'b0);
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_random();
    t_boundary();
    t_stream();
    t_hold();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule